// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Lead-In and Repeat Count

This block is a bank of independent pulse-width modulation channels behind a simple word-addressed register port. Each channel drives one output. The waveform is a high phase followed by a low phase, and each phase length is counted in input clock cycles. When a channel is enabled, it first holds its output low for a programmable lead-in interval. It then produces periods either forever or for a programmed number of periods. After the last period the output rests low.

Software programs two 32-bit registers per channel: a control word and a timing word. The control word holds the enable, the lead-in length and the repeat count. The timing word holds the high length and the low length. The timing word is a shadow copy that the channel picks up only when a new period starts, so a rewrite never shortens or distorts the period in flight. Clearing the enable bit, by contrast, forces the output low at once, whatever phase the channel is in.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: The byte address selects the register as follows. Bit 5 chooses the timing word (1) or the control word (0). Bits 4:2 give the channel index. Every field of a mapped register reads back exactly as written. An index at or above the channel count reads zero, and writes to it have no effect.
- R3: In the control word, bit 31 is the enable, bits 30:16 are the lead-in length and bits 15:0 are the repeat count. After the clock edge that writes enable=1, the output stays low for 1 + lead-in cycles and then the first period begins.
- R4: In the timing word, bits 31:16 are the high length H and bits 15:0 are the low length L. Each period drives the output high for H cycles and then low for L cycles.
- R5: With a nonzero repeat count N, the channel stops after N complete periods and holds its output low. The enable bit still reads back as 1.
- R6: With a repeat count of zero, periods continue without end while the channel is enabled.
- R7: A timing word written during a period does not alter that period. The new H and L apply from the next period onward.
- R8: A write that clears the enable bit drives the output low from that clock edge, without finishing the current period.
- R9: H=0 gives a constant low output. L=0 with H>0 gives a constant high output. Neither case produces a glitch pulse at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all phase lengths count its cycles |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 6 | Byte address for read and write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| pwmOut | output | NUM_CH | One waveform output per channel |

## Verification
The bench uses the default of six channels. The 3-bit channel index then has two unused codes, 6 and 7, which exercises the check that unmapped slots read zero and ignore writes. Each channel under test is given small phase lengths of 0 to 5 cycles and lead-in lengths of 0 or 4. This keeps lead-in expiry, period boundaries, the final period of a finite run and the zero-length phase cases within a few dozen cycles, where a cycle-by-cycle expected waveform can be compared in full.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 16;
  localparam int LEAD_W = 15;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_DONE
  } chState_t;

  // control word layout: enable | lead-in | repeat count (MSB to LSB)
  typedef struct packed {
    logic              en;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  rep;
  } ctrlReg_t;

  // timing word layout: high length | low length
  typedef struct packed {
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } timeReg_t;

  // strobes from a channel's control FSM to its datapath
  typedef struct packed {
    logic loadLead;
    logic startPeriod;
    logic enterLow;
    logic countDown;
    logic clrPeriods;
    logic incPeriods;
  } chStrobe_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output ctrlReg_t          ctrlQ [NUM_CH],
  output timeReg_t          timeQ [NUM_CH]
);
  logic             isTime;
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign isTime = regAddr[ADDR_W-1];
  assign idx    = regAddr[IDX_W+1:2];
  assign hit    = (int'(idx) < NUM_CH);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    logic sel;
    assign sel = regWr && hit && (idx == IDX_W'(ch));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ[ch] <= '0;
        timeQ[ch] <= '0;
      end else if (sel) begin
        if (isTime) timeQ[ch] <= timeReg_t'(regWdata);
        else        ctrlQ[ch] <= ctrlReg_t'(regWdata);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (hit && idx == IDX_W'(ch))
        regRdata = isTime ? REG_W'(timeQ[ch]) : REG_W'(ctrlQ[ch]);
    end
  end
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      en,
  input  logic      leadZero,
  input  logic      shHighZero,
  input  logic      actLowZero,
  input  logic      cntZero,
  input  logic      lastPeriod,
  output chState_t  state,
  output chStrobe_t stb
);
  chState_t nxt;
  chState_t startSt;
  logic     goStart;
  logic     endPeriod;

  assign startSt = shHighZero ? ST_LOW : ST_HIGH;

  always_comb begin
    nxt       = state;
    stb       = '0;
    goStart   = 1'b0;
    endPeriod = 1'b0;
    if (!en) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stb.clrPeriods = 1'b1;
          if (!leadZero) begin
            nxt          = ST_LEAD;
            stb.loadLead = 1'b1;
          end else begin
            goStart = 1'b1;
          end
        end
        ST_LEAD: begin
          if (cntZero) goStart = 1'b1;
          else         stb.countDown = 1'b1;
        end
        ST_HIGH: begin
          if (!cntZero) begin
            stb.countDown = 1'b1;
          end else if (!actLowZero) begin
            nxt          = ST_LOW;
            stb.enterLow = 1'b1;
          end else begin
            endPeriod = 1'b1;
          end
        end
        ST_LOW: begin
          if (!cntZero) stb.countDown = 1'b1;
          else          endPeriod = 1'b1;
        end
        ST_DONE: ;
        default: nxt = ST_IDLE;
      endcase
      if (endPeriod) begin
        stb.incPeriods = 1'b1;
        if (lastPeriod) nxt = ST_DONE;
        else            goStart = 1'b1;
      end
      if (goStart) begin
        stb.startPeriod = 1'b1;
        nxt             = startSt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chStrobe_t stb,
  input  chState_t  state,
  input  ctrlReg_t  ctrl,
  input  timeReg_t  shTime,
  output logic      leadZero,
  output logic      shHighZero,
  output logic      actLowZero,
  output logic      cntZero,
  output logic      lastPeriod,
  output logic      pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actLow;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] firstLen;

  assign leadZero   = (ctrl.lead == '0);
  assign shHighZero = (shTime.high == '0);
  assign actLowZero = (actLow == '0);
  assign cntZero    = (cnt == '0);
  assign lastPeriod = (ctrl.rep != '0) &&
                      ({1'b0, periodCnt} + 1'b1 == {1'b0, ctrl.rep});

  // first phase length of a new period, taken from the shadow word
  always_comb begin
    if (!shHighZero)            firstLen = shTime.high - 1'b1;
    else if (shTime.low != '0)  firstLen = shTime.low - 1'b1;
    else                        firstLen = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      actLow    <= '0;
      periodCnt <= '0;
    end else begin
      if (stb.loadLead) begin
        cnt <= CNT_W'(ctrl.lead) - 1'b1;
      end else if (stb.startPeriod) begin
        cnt    <= firstLen;
        actLow <= shTime.low;
      end else if (stb.enterLow) begin
        cnt <= actLow - 1'b1;
      end else if (stb.countDown) begin
        cnt <= cnt - 1'b1;
      end
      if (stb.clrPeriods)      periodCnt <= '0;
      else if (stb.incPeriods) periodCnt <= periodCnt + 1'b1;
    end
  end

  assign pwmOut = ctrl.en && (state == ST_HIGH);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  ctrlReg_t          ctrlQ [NUM_CH];
  timeReg_t          timeQ [NUM_CH];
  logic [NUM_CH-1:0] chanEn;

  pwm_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ctrlQ(ctrlQ), .timeQ(timeQ)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    chState_t  state;
    chStrobe_t stb;
    logic      leadZero, shHighZero, actLowZero, cntZero, lastPeriod;

    assign chanEn[ch] = ctrlQ[ch].en;

    pwm_chan_ctrl u_ctrl (
      .clk(clk), .rstN(rstN), .en(ctrlQ[ch].en), .leadZero(leadZero),
      .shHighZero(shHighZero), .actLowZero(actLowZero), .cntZero(cntZero),
      .lastPeriod(lastPeriod), .state(state), .stb(stb)
    );

    pwm_chan_dp u_dp (
      .clk(clk), .rstN(rstN), .stb(stb), .state(state), .ctrl(ctrlQ[ch]),
      .shTime(timeQ[ch]), .leadZero(leadZero), .shHighZero(shHighZero),
      .actLowZero(actLowZero), .cntZero(cntZero), .lastPeriod(lastPeriod),
      .pwmOut(pwmOut[ch])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [5:0]        regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] chanEn
);
  logic mapped;
  assign mapped = (int'(regAddr[4:2]) < NUM_CH);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && mapped) ##1 (regAddr == $past(regAddr)) |-> regRdata == $past(regWdata));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> regRdata == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    // R8
    disable_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && !regAddr[5] && regAddr[4:2] == 3'(ch) && !regWdata[31]) |=> !pwmOut[ch]);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanEn[ch]) |-> !pwmOut[ch]);

    // R8
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[ch]) |-> $past(chanEn[ch]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut), .chanEn(chanEn)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  localparam int NUM_CH = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWr = 1'b0;
  logic [5:0]        regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic [NUM_CH-1:0] pwmOut;

  int total = 0;
  int bad = 0;
  int expQ[$];
  int pendQ[$];

  always #2 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut)
  );

  function automatic logic [5:0] ctrlAddr(int ch); return 6'(4 * ch); endfunction
  function automatic logic [5:0] timeAddr(int ch); return 6'(32 + 4 * ch); endfunction
  function automatic logic [31:0] ctrlWord(bit en, int lead, int rep);
    return {en, 15'(lead), 16'(rep)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stage expected output bits; they go live at the next write's edge
  task automatic pushPat(int ch, bit b, int n);
    for (int i = 0; i < n; i++) pendQ.push_back(ch * 2 + int'(b));
  endtask

  task automatic regWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    while (pendQ.size() > 0) expQ.push_back(pendQ.pop_front());
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // monitor: one expected bit per cycle, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      int item;
      int ch;
      bit b;
      item = expQ.pop_front();
      ch = item / 2;
      b = item[0];
      chk(pwmOut[ch] == b, $sformatf("R4 waveform ch%0d", ch), 32'(pwmOut[ch]), 32'(b));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(pwmOut == '0, "R1 outputs", 32'(pwmOut), 0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      regRead(ctrlAddr(ch), rd); chk(rd == 0, "R1 ctrl", rd, 0);
      regRead(timeAddr(ch), rd); chk(rd == 0, "R1 time", rd, 0);
    end

    // R2 readback of every field, channel disabled
    regWrite(timeAddr(3), 32'hA5C3_1E7F);
    regWrite(ctrlAddr(3), 32'h5A3C_81FE);
    regRead(timeAddr(3), rd); chk(rd == 32'hA5C3_1E7F, "R2 time readback", rd, 32'hA5C3_1E7F);
    regRead(ctrlAddr(3), rd); chk(rd == 32'h5A3C_81FE, "R2 ctrl readback", rd, 32'h5A3C_81FE);
    regWrite(ctrlAddr(3), 0);
    // R2 unmapped slot 6 and 7
    regWrite(ctrlAddr(6), 32'hFFFF_FFFF);
    regWrite(timeAddr(7), 32'h1234_5678);
    regRead(ctrlAddr(6), rd); chk(rd == 0, "R2 unmapped ctrl", rd, 0);
    regRead(timeAddr(7), rd); chk(rd == 0, "R2 unmapped time", rd, 0);
    chk(pwmOut == '0, "R2 unmapped write no output", 32'(pwmOut), 0);

    // R3 R4 R5: lead-in 4, H=3 L=2, two periods then rest low
    regWrite(timeAddr(0), {16'd3, 16'd2});
    pushPat(0, 0, 1 + 4);
    for (int p = 0; p < 2; p++) begin pushPat(0, 1, 3); pushPat(0, 0, 2); end
    pushPat(0, 0, 8);
    regWrite(ctrlAddr(0), ctrlWord(1, 4, 2));
    drain();
    regRead(ctrlAddr(0), rd);
    chk(rd == ctrlWord(1, 4, 2), "R5 enable kept after finish", rd, ctrlWord(1, 4, 2));
    regWrite(ctrlAddr(0), 0);

    // R9 H=0: constant low, no lead-in, forever
    regWrite(timeAddr(1), {16'd0, 16'd3});
    pushPat(1, 0, 16);
    regWrite(ctrlAddr(1), ctrlWord(1, 0, 0));
    drain();
    regWrite(ctrlAddr(1), 0);

    // R9 R6 L=0: constant high after one idle cycle
    regWrite(timeAddr(2), {16'd2, 16'd0});
    pushPat(2, 0, 1);
    pushPat(2, 1, 14);
    regWrite(ctrlAddr(2), ctrlWord(1, 0, 0));
    drain();
    regWrite(ctrlAddr(2), 0);

    // R7 R6: timing rewritten mid-period applies at the next period
    regWrite(timeAddr(4), {16'd4, 16'd4});
    pushPat(4, 0, 1);
    pushPat(4, 1, 4); pushPat(4, 0, 4);
    for (int p = 0; p < 5; p++) begin pushPat(4, 1, 1); pushPat(4, 0, 1); end
    regWrite(ctrlAddr(4), ctrlWord(1, 0, 0));
    regWrite(timeAddr(4), {16'd1, 16'd1});
    drain();
    regWrite(ctrlAddr(4), 0);

    // R8 disable mid-high cuts the output at once
    regWrite(timeAddr(5), {16'd5, 16'd5});
    regWrite(ctrlAddr(5), ctrlWord(1, 0, 0));
    do @(negedge clk); while (!pwmOut[5]);
    regWrite(ctrlAddr(5), 0);
    chk(pwmOut[5] == 1'b0, "R8 low right after disable", 32'(pwmOut[5]), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(pwmOut[5] == 1'b0, "R8 stays low", 32'(pwmOut[5]), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule